// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words that crosses between two clock domains. A producer pushes words on its own clock with a write enable. A consumer pulls words on a second clock with a read enable. Each pulled word lands in an output register. The two clocks may be the same net or fully unrelated. Each side owns the flags it needs. The write side drives `full` and `almost_full`. The read side drives `empty` and `almost_empty`.

The two fill thresholds are held as a pair of 16-bit offsets. Software on the producer side loads them through the ordinary data port while a load strobe is held high. Four byte-wide write beats fill the register in a fixed order. A retransmit input on the read side rewinds the read position to the first location of the array. The consumer can then replay everything written since reset. Replay is valid as long as no more than the array depth has been written since reset. An asynchronous reset returns both domains to an empty buffer and restores the default offsets.

Top module: `xclk_flag_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `almost_empty`=1, `almost_full`=0 and `rd_data`=0. Both offsets are 7, because each low byte resets to 0x07 and each high byte to 0x00.
- R2: Every rising `wclk` edge with `wr_en`=1, `ld_en`=0 and `full`=0 stores `wr_data`. Every rising `rclk` edge with `rd_en`=1 and `empty`=0 loads the oldest unread word into `rd_data`, so words come out in the order they were written.
- R3: A read request while `empty`=1 is ignored. `rd_data` keeps its value, and the next word written is the next word read.
- R4: `full` rises once DEPTH (64 by default) words are unread. A write while `full`=1 is ignored, and that word is never delivered.
- R5: A `wclk` edge with `wr_en`=1 and `ld_en`=1 stores `wr_data[7:0]` into the offset register instead of the buffer. Successive beats go to a rotating byte slot: empty-offset low byte, empty-offset high byte, full-offset low byte, full-offset high byte, then back to the first.
- R6: `almost_empty`=1 exactly when the unread count, as seen by the read domain, is less than or equal to the empty offset. The offset reaches the read domain through one register stage.
- R7: `almost_full`=1 exactly when the unread count, as seen by the write domain, is at least DEPTH minus the full offset. An offset at or above DEPTH gives a threshold of 0.
- R8: A one-cycle `rtx` pulse sets the read position to location 0. Reading resumes from the first word written since reset, and the flags follow the new position.
- R9: When `empty` falls, a read issued on the next `rclk` edge presents the first stored word on `rd_data` after that edge.
- R10: With `rclk` and `wclk` at unrelated frequencies, every word written is read back once, unaltered and in order. The pointers cross the domains as Gray codes through two-stage synchronisers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| arst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_en | input | 1 | Write enable, one word or offset byte per edge |
| ld_en | input | 1 | Steers write beats into the offset register |
| wr_data | input | 9 | Word to store; bits 7:0 carry an offset byte |
| full | output | 1 | Buffer holds DEPTH unread words (write domain) |
| almost_full | output | 1 | Unread count at or above DEPTH minus full offset |
| rclk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read enable |
| rtx | input | 1 | Retransmit: rewind read position to location 0 |
| rd_data | output | 9 | Output register holding the last word read |
| empty | output | 1 | No unread words (read domain) |
| almost_empty | output | 1 | Unread count at or below empty offset |

## Verification
The case hardest to reach from the ports is the high byte of an offset taking effect. With a 64-word array, a high byte only matters once it lifts the offset far beyond the depth. The stimulus loads an empty-offset high byte of 1, which gives an offset of 256. It then fills the array to the top and shows that `almost_empty` never drops. The stimulus also fills exactly to DEPTH, pushes one more word, and drains the array. The drain shows that the refused word never surfaces. A separate run uses a read clock of a different period, with read pacing driven by `empty`, to exercise both synchroniser paths.

// File: rtl/xff_pkg.sv
package xff_pkg;

  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ofs_slot_e;

  localparam logic [7:0] OFS_LO_RST = 8'h07;
  localparam logic [7:0] OFS_HI_RST = 8'h00;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Fill level at which the almost-full flag rises.
  function automatic logic [31:0] af_limit(input logic [31:0] depth,
                                           input logic [31:0] ofs);
    return (ofs >= depth) ? 32'd0 : depth - ofs;
  endfunction

  function automatic logic ae_hit(input logic [31:0] level,
                                  input logic [31:0] ofs);
    return level <= ofs;
  endfunction

endpackage

// File: rtl/xff_sync.sv
module xff_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/xff_dpram.sv
module xff_dpram #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          arst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge arst_n) begin
    if (!arst_n)  rdata <= '0;
    else if (re)  rdata <= mem[raddr];
  end
endmodule

// File: rtl/xff_wr_ctl.sv
module xff_wr_ctl
  import xff_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          arst_n,
  input  logic          wr_en,
  input  logic          ld_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   rgray_sync,
  output logic          wr_fire,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          almost_full,
  output logic [15:0]   ae_ofs
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic       ld_fire;
  ofs_slot_e  slot_q;
  logic [7:0] ofs_q [4];
  logic [15:0] af_ofs;
  logic [PW-1:0] wbin_nxt, wgray_nxt, rbin_sync, wlevel_nxt, full_pat;
  logic full_nxt, af_nxt;

  assign ld_fire = wr_en & ld_en;
  assign wr_fire = wr_en & ~ld_en & ~full;

  // Offset register: one byte per load beat, rotating slot.
  always_ff @(posedge wclk or negedge arst_n) begin
    if (!arst_n) begin
      slot_q <= SLOT_AE_LO;
      for (int i = 0; i < 4; i++) ofs_q[i] <= (i % 2 == 0) ? OFS_LO_RST : OFS_HI_RST;
    end else if (ld_fire) begin
      ofs_q[slot_q] <= wr_data[7:0];
      slot_q        <= ofs_slot_e'(slot_q + 2'd1);
    end
  end

  assign ae_ofs = {ofs_q[SLOT_AE_HI], ofs_q[SLOT_AE_LO]};
  assign af_ofs = {ofs_q[SLOT_AF_HI], ofs_q[SLOT_AF_LO]};

  assign wbin_nxt   = wbin + PW'(wr_fire);
  assign wgray_nxt  = PW'(bin2gray(32'(wbin_nxt)));
  assign rbin_sync  = PW'(gray2bin(32'(rgray_sync)));
  assign wlevel_nxt = wbin_nxt - rbin_sync;
  assign full_pat   = {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};
  assign full_nxt   = (wgray_nxt == full_pat);
  assign af_nxt     = 32'(wlevel_nxt) >= af_limit(32'(DEPTH), 32'(af_ofs));

  always_ff @(posedge wclk or negedge arst_n) begin
    if (!arst_n) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin        <= wbin_nxt;
      wgray       <= wgray_nxt;
      full        <= full_nxt;
      almost_full <= af_nxt;
    end
  end
endmodule

// File: rtl/xff_rd_ctl.sv
module xff_rd_ctl
  import xff_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic        rclk,
  input  logic        arst_n,
  input  logic        rd_en,
  input  logic        rtx,
  input  logic [AW:0] wgray_sync,
  input  logic [15:0] ae_ofs,
  output logic        rd_fire,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray,
  output logic        empty,
  output logic        almost_empty
);
  localparam int PW = AW + 1;

  logic [15:0]   ae_ofs_r;
  logic [PW-1:0] rbin_nxt, rgray_nxt, wbin_sync, rlevel_nxt;
  logic          empty_nxt, ae_nxt;

  assign rd_fire    = rd_en & ~empty & ~rtx;
  assign rbin_nxt   = rtx ? '0 : rbin + PW'(rd_fire);
  assign rgray_nxt  = PW'(bin2gray(32'(rbin_nxt)));
  assign wbin_sync  = PW'(gray2bin(32'(wgray_sync)));
  assign rlevel_nxt = wbin_sync - rbin_nxt;
  assign empty_nxt  = (rgray_nxt == wgray_sync);
  assign ae_nxt     = ae_hit(32'(rlevel_nxt), 32'(ae_ofs_r));

  always_ff @(posedge rclk or negedge arst_n) begin
    if (!arst_n) begin
      ae_ofs_r     <= {OFS_HI_RST, OFS_LO_RST};
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      ae_ofs_r     <= ae_ofs;
      rbin         <= rbin_nxt;
      rgray        <= rgray_nxt;
      empty        <= empty_nxt;
      almost_empty <= ae_nxt;
    end
  end
endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          arst_n,
  input  logic          wr_en,
  input  logic          ld_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  input  logic          rclk,
  input  logic          rd_en,
  input  logic          rtx,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  // Named internal events, observed by the bound checker.
  logic          wr_fire, rd_fire;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] wgray, rgray, wgray_sync, rgray_sync;
  logic [15:0]   ae_ofs;

  xff_wr_ctl #(.AW(AW), .DW(DW)) u_wr (
    .wclk(wclk), .arst_n(arst_n), .wr_en(wr_en), .ld_en(ld_en),
    .wr_data(wr_data), .rgray_sync(rgray_sync), .wr_fire(wr_fire),
    .wbin(wr_ptr), .wgray(wgray), .full(full), .almost_full(almost_full),
    .ae_ofs(ae_ofs)
  );

  xff_rd_ctl #(.AW(AW)) u_rd (
    .rclk(rclk), .arst_n(arst_n), .rd_en(rd_en), .rtx(rtx),
    .wgray_sync(wgray_sync), .ae_ofs(ae_ofs), .rd_fire(rd_fire),
    .rbin(rd_ptr), .rgray(rgray), .empty(empty), .almost_empty(almost_empty)
  );

  xff_sync #(.W(PW)) u_w2r (.clk(rclk), .arst_n(arst_n), .d(wgray), .q(wgray_sync));
  xff_sync #(.W(PW)) u_r2w (.clk(wclk), .arst_n(arst_n), .d(rgray), .q(rgray_sync));

  xff_dpram #(.AW(AW), .DW(DW)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
    .rclk(rclk), .arst_n(arst_n), .re(rd_fire), .raddr(rd_ptr[AW-1:0]),
    .rdata(rd_data)
  );
endmodule

// File: rtl/xff_chk.sv
module xff_chk #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          arst_n,
  input logic          wr_en,
  input logic          ld_en,
  input logic          rd_en,
  input logic          rtx,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty,
  input logic [DW-1:0] rd_data,
  input logic          wr_fire,
  input logic [AW:0]   wr_ptr,
  input logic [AW:0]   rd_ptr
);
  AST_PTR_STEP: assert property (@(posedge wclk) disable iff (!arst_n)
    wr_fire |=> wr_ptr == $past(wr_ptr) + 1'b1); // R2
  AST_RD_IGNORED_EMPTY: assert property (@(posedge rclk) disable iff (!arst_n)
    (empty && rd_en && !rtx) |=> ($stable(rd_data) && $stable(rd_ptr))); // R3
  AST_WR_IGNORED_FULL: assert property (@(posedge wclk) disable iff (!arst_n)
    (full && wr_en && !ld_en) |=> $stable(wr_ptr)); // R4
  AST_LOAD_NO_STORE: assert property (@(posedge wclk) disable iff (!arst_n)
    (wr_en && ld_en) |=> $stable(wr_ptr)); // R5
  AST_EMPTY_IN_AE: assert property (@(posedge rclk) disable iff (!arst_n)
    empty |-> almost_empty); // R6
  AST_FULL_IN_AF: assert property (@(posedge wclk) disable iff (!arst_n)
    full |-> almost_full); // R7
  AST_RTX_REWIND: assert property (@(posedge rclk) disable iff (!arst_n)
    rtx |=> rd_ptr == '0); // R8
endmodule

bind xclk_flag_fifo xff_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .wr_en(wr_en), .ld_en(ld_en),
  .rd_en(rd_en), .rtx(rtx), .full(full), .almost_full(almost_full),
  .empty(empty), .almost_empty(almost_empty), .rd_data(rd_data),
  .wr_fire(wr_fire), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/xclk_flag_fifo_tb.sv
module xclk_flag_fifo_tb;
  localparam int DEPTH = 64;

  logic wclk = 0, rclk_slow = 0, split = 0;
  logic rclk;
  logic arst_n = 0, wr_en = 0, ld_en = 0, rd_en = 0, rtx = 0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic full, almost_full, empty, almost_empty;
  int pass_n = 0, fail_n = 0;
  bit done = 0;

  always #2 wclk = ~wclk;
  always #3.5 rclk_slow = ~rclk_slow;
  assign rclk = split ? rclk_slow : wclk;

  xclk_flag_fifo u_dut (
    .wclk(wclk), .arst_n(arst_n), .wr_en(wr_en), .ld_en(ld_en),
    .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .rclk(rclk), .rd_en(rd_en), .rtx(rtx), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    arst_n = 0; wr_en = 0; ld_en = 0; rd_en = 0; rtx = 0; wr_data = '0;
    repeat (3) @(negedge wclk);
    arst_n = 1;
    @(negedge wclk);
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  task automatic push_n(input int base, input int step, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); wr_en = 1; wr_data = 9'(base + i * step);
    end
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic load4(input logic [7:0] b0, b1, b2, b3);
    @(negedge wclk); ld_en = 1; wr_en = 1; wr_data = {1'b0, b0};
    @(negedge wclk); wr_data = {1'b1, b1};
    @(negedge wclk); wr_data = {1'b0, b2};
    @(negedge wclk); wr_data = {1'b1, b3};
    @(negedge wclk); ld_en = 0; wr_en = 0;
  endtask

  task automatic pop(output logic [8:0] v);
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    v = rd_data;
  endtask

  task automatic t_reset();
    do_reset();
    chk(empty == 1, "R1 empty", empty, 1);
    chk(full == 0, "R1 full", full, 0);
    chk(almost_empty == 1, "R1 almost_empty", almost_empty, 1);
    chk(almost_full == 0, "R1 almost_full", almost_full, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_defaults();
    do_reset();
    push_n(1, 1, 7); settle();
    chk(almost_empty == 1, "R1 default ae offset 7 at 7", almost_empty, 1);
    push_n(8, 1, 1); settle();
    chk(almost_empty == 0, "R1 default ae offset 7 at 8", almost_empty, 0);
    push_n(9, 1, 48); settle();
    chk(almost_full == 0, "R1 default af offset 7 at 56", almost_full, 0);
    push_n(57, 1, 1); settle();
    chk(almost_full == 1, "R1 default af offset 7 at 57", almost_full, 1);
  endtask

  task automatic t_order();
    logic [8:0] v;
    do_reset();
    push_n(9'h100, 3, 5); settle();
    chk(empty == 0, "R2 not empty", empty, 0);
    for (int i = 0; i < 5; i++) begin
      pop(v);
      chk(v == 9'(9'h100 + i * 3), "R2 order", v, 9'h100 + i * 3);
    end
    settle();
    chk(empty == 1, "R2 drained", empty, 1);
  endtask

  task automatic t_empty_read();
    logic [8:0] v0, v;
    v0 = rd_data;
    pop(v); pop(v);
    chk(rd_data == v0, "R3 read when empty ignored", rd_data, v0);
    push_n(9'h055, 0, 1); settle();
    pop(v);
    chk(v == 9'h055, "R3 pointer unchanged", v, 9'h055);
  endtask

  task automatic t_first();
    int guard = 0;
    do_reset();
    push_n(9'h1A2, 0, 1);
    @(negedge rclk);
    while (empty && guard < 50) begin @(negedge rclk); guard++; end
    chk(rd_data == 0, "R9 word not visible before read", rd_data, 0);
    rd_en = 1;
    @(negedge rclk); rd_en = 0;
    chk(rd_data == 9'h1A2, "R9 first word after one read", rd_data, 9'h1A2);
  endtask

  task automatic t_full();
    logic [8:0] v;
    do_reset();
    push_n(1, 5, DEPTH); settle();
    chk(full == 1, "R4 full at depth", full, 1);
    push_n(9'h1FF, 0, 1); settle();
    chk(full == 1, "R4 still full", full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(v);
      chk(v == 9'(1 + i * 5), "R4 content", v, 9'(1 + i * 5));
    end
    settle();
    chk(empty == 1, "R4 extra word dropped", empty, 1);
    chk(full == 0, "R4 full cleared", full, 0);
  endtask

  task automatic t_load();
    do_reset();
    load4(8'd3, 8'd0, 8'd10, 8'd0); settle();
    chk(empty == 1, "R5 load beats not stored", empty, 1);
    push_n(1, 1, 3); settle();
    chk(almost_empty == 1, "R6 ae at offset", almost_empty, 1);
    push_n(4, 1, 1); settle();
    chk(almost_empty == 0, "R6 ae above offset", almost_empty, 0);
    push_n(5, 1, 49); settle();
    chk(almost_full == 0, "R7 af below 54", almost_full, 0);
    push_n(54, 1, 1); settle();
    chk(almost_full == 1, "R7 af at 54", almost_full, 1);
    do_reset();
    load4(8'd0, 8'd1, 8'd0, 8'd0);
    push_n(1, 1, DEPTH); settle();
    chk(full == 1, "R5 full after load", full, 1);
    chk(almost_empty == 1, "R5 ae high byte 256", almost_empty, 1);
    chk(almost_full == 1, "R7 af offset 0 at full", almost_full, 1);
  endtask

  task automatic t_rtx();
    logic [8:0] v;
    do_reset();
    push_n(9'h0C0, 7, 4); settle();
    pop(v); pop(v);
    chk(v == 9'h0C7, "R8 pre-rewind", v, 9'h0C7);
    @(negedge rclk); rtx = 1;
    @(negedge rclk); rtx = 0;
    settle();
    for (int i = 0; i < 4; i++) begin
      pop(v);
      chk(v == 9'(9'h0C0 + i * 7), "R8 replay", v, 9'h0C0 + i * 7);
    end
    settle();
    chk(empty == 1, "R8 empty after replay", empty, 1);
  endtask

  task automatic t_split();
    logic [8:0] v;
    split = 1;
    do_reset();
    push_n(9'h013, 11, 20);
    for (int i = 0; i < 20; i++) begin
      int guard = 0;
      @(negedge rclk);
      while (empty && guard < 50) begin @(negedge rclk); guard++; end
      rd_en = 1;
      @(negedge rclk); rd_en = 0;
      v = rd_data;
      chk(v == 9'(9'h013 + i * 11), "R10 independent clocks", v, 9'h013 + i * 11);
    end
    settle();
    chk(empty == 1, "R10 drained", empty, 1);
    split = 0;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      fail_n++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_defaults();
    t_order();
    t_empty_read();
    t_first();
    t_full();
    t_load();
    t_rtx();
    t_split();
    done = 1;
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule